// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block holds the status byte of a small two-sector serial flash and decides whether each write-type command may run. It sits behind a byte-level command front end. A chip-select level frames each transaction, and received bytes arrive on a valid-qualified input stream. The first byte is the opcode, and the later bytes are arguments. A command takes effect only once chip select is released. At that point the block checks the command against the write-enable latch, the block-protect field and the hardware lock formed by the status-lock bit together with the write-protect pin. An accepted status write, program or erase starts an internal timed cycle that holds the busy flag high.

A status read starts as soon as its opcode arrives. It then streams the live status byte on a valid/ready output for as long as chip select stays asserted. The input stream has no back-pressure: every byte offered while chip select is high is taken. On the output, `tx_byte` is a snapshot. It holds still while `tx_ready` is low and is refreshed after each accepted transfer. The lock bit and protect field model nonvolatile storage: only the power-on reset clears them, and the logical reset leaves them alone.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: lock, 0, 0, 0, protect[1], protect[0], write-enable latch, busy. Bits 6..4 always read 0. A status write takes only its bits 7, 3 and 2.
- R2: Busy reads 1 for exactly T_WRSR, T_PP, T_SE or T_BE clock cycles after an accepted status write, page program, sector erase or bulk erase respectively.
- R3: While busy is 1, every command except the status read is ignored.
- R4: While the write-enable latch is 0, status write (0x01), page program (0x02), sector erase (0xD8) and bulk erase (0xC7) are ignored, and the latch and busy stay unchanged.
- R5: Opcode 0x06 sets the write-enable latch and 0x04 clears it. The latch also clears when an accepted timed cycle ends.
- R6: A command is acted on only when chip select drops. It must have exactly 1 byte for 0x06, 0x04 and 0xC7, exactly 2 bytes for 0x01 and 0xD8, and at least 3 bytes for 0x02. Any other length is ignored. For 0x02 and 0xD8, bit 7 of the second byte selects the sector (1 = upper).
- R7: Program and sector erase are rejected on a protected sector. Protect 00 guards no sector, 01 guards the upper sector, and 10 or 11 guards both sectors.
- R8: Bulk erase runs only when protect is 00.
- R9: When the lock bit is 1 and `wp_n` is 0, the status write is rejected, so lock and protect cannot change. Other commands are not affected.
- R10: After opcode 0x05, `tx_valid` stays high until chip select drops. `tx_byte` holds while `tx_ready` is low, and each handshake loads the current status. Reads are served while busy.
- R11: `rst_n` clears the latch, busy and the read state but keeps lock and protect. `por_n` clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears nonvolatile bits too |
| rst_n | input | 1 | Logical reset, active low |
| cs_active | input | 1 | Chip select, high frames a transaction |
| wp_n | input | 1 | Write-protect pin, active low |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Consumer takes the status byte |
| tx_valid | output | 1 | Status byte is offered |
| tx_byte | output | 8 | Status byte |
| busy | output | 1 | Internal timed cycle running |

## Verification
Several behaviours are checked on every cycle:
- the lock keeps lock and protect stable while the pin is low;
- a timed cycle never starts without the latch;
- commands during busy leave the latch alone;
- a blocked bulk erase never raises busy;
- the output byte holds under back-pressure, with its zero bits clear.

Other behaviours only show up through the bench's scenarios: the exact busy length for each kind, the sector decode for each protect value, the command-length rules, and the split between the two resets. The same goes for streaming a fresh status, bit by bit, across the end of a cycle.

// File: rtl/flash_sg_pkg.sv
package flash_sg_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  typedef enum logic [2:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PP, K_SE, K_BE
  } kind_t;

  typedef struct packed {
    logic       valid;
    kind_t      kind;
    logic       upper;    // sector select from address byte
    logic       nv_lock;  // new lock bit for a status write
    logic [1:0] nv_bp;    // new protect field for a status write
  } cmd_t;
endpackage

// File: rtl/fsg_cmd_decode.sv
module fsg_cmd_decode
  import flash_sg_pkg::*;
#(
  parameter int SECTOR_BIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output cmd_t       cmd,
  output logic       rd_start
);
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             cs_q;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       op;
  logic             upper_q, lock_q;
  logic [1:0]       bp_q;
  kind_t            kind_c;

  // R6: classify by opcode and exact byte count at release
  always_comb begin
    kind_c = K_NONE;
    unique case (op)
      OP_WREN: if (cnt == 2'd1) kind_c = K_WREN;
      OP_WRDI: if (cnt == 2'd1) kind_c = K_WRDI;
      OP_BE:   if (cnt == 2'd1) kind_c = K_BE;
      OP_WRSR: if (cnt == 2'd2) kind_c = K_WRSR;
      OP_SE:   if (cnt == 2'd2) kind_c = K_SE;
      OP_PP:   if (cnt == CNT_SAT) kind_c = K_PP;
      default: kind_c = K_NONE;
    endcase
  end

  assign rd_start = cs_active && rx_valid && (cnt == '0) && (rx_byte == OP_RDSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      cnt     <= '0;
      op      <= '0;
      upper_q <= 1'b0;
      lock_q  <= 1'b0;
      bp_q    <= '0;
      cmd     <= '0;
    end else begin
      cs_q <= cs_active;
      cmd  <= '0;
      if (cs_active) begin
        if (rx_valid) begin
          if (cnt == '0) op <= rx_byte;
          if (cnt == 2'd1) begin
            upper_q <= rx_byte[SECTOR_BIT];
            lock_q  <= rx_byte[7];
            bp_q    <= rx_byte[3:2];
          end
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
        if (cs_q) begin
          cmd.valid   <= (kind_c != K_NONE);
          cmd.kind    <= kind_c;
          cmd.upper   <= upper_q;
          cmd.nv_lock <= lock_q;
          cmd.nv_bp   <= bp_q;
        end
      end
    end
  end
endmodule

// File: rtl/fsg_protect.sv
module fsg_protect
  import flash_sg_pkg::*;
(
  input  cmd_t       cmd,
  input  logic       busy,
  input  logic       wel,
  input  logic       lock,
  input  logic [1:0] bp,
  input  logic       wp_n,
  output logic       accept
);
  logic sector_guarded;
  logic hw_locked;

  // R7: two-sector protect decode
  always_comb begin
    unique case (bp)
      2'b00:   sector_guarded = 1'b0;
      2'b01:   sector_guarded = cmd.upper;
      default: sector_guarded = 1'b1;
    endcase
  end

  assign hw_locked = lock && !wp_n;  // R9

  always_comb begin
    accept = 1'b0;
    if (cmd.valid && !busy) begin  // R3
      unique case (cmd.kind)
        K_WREN, K_WRDI: accept = 1'b1;
        K_WRSR:         accept = wel && !hw_locked;        // R4 R9
        K_PP, K_SE:     accept = wel && !sector_guarded;   // R4 R7
        K_BE:           accept = wel && (bp == 2'b00);     // R4 R8
        default:        accept = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fsg_busy_timer.sv
module fsg_busy_timer
  import flash_sg_pkg::*;
#(
  parameter int unsigned T_WRSR = 200,
  parameter int unsigned T_PP   = 3000,
  parameter int unsigned T_SE   = 20000,
  parameter int unsigned T_BE   = 60000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  kind_t kind,
  output logic  busy,
  output logic  done
);
  localparam int unsigned MAX_A = (T_WRSR > T_PP) ? T_WRSR : T_PP;
  localparam int unsigned MAX_B = (T_SE > T_BE) ? T_SE : T_BE;
  localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = $clog2(MAX_D + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  // R2: per-kind duration, loaded as count minus one
  always_comb begin
    unique case (kind)
      K_WRSR:  load_val = CW'(T_WRSR - 1);
      K_PP:    load_val = CW'(T_PP - 1);
      K_SE:    load_val = CW'(T_SE - 1);
      K_BE:    load_val = CW'(T_BE - 1);
      default: load_val = '0;
    endcase
  end

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  a_r2_busy_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !start) |=> busy);
endmodule

// File: rtl/fsg_status_reader.sv
module fsg_status_reader (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       rd_start,
  input  logic [7:0] status,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  logic reading;

  assign tx_valid = reading;

  // R10: snapshot on entry and after each handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading <= 1'b0;
      tx_byte <= '0;
    end else if (!cs_active) begin
      reading <= 1'b0;
    end else if (rd_start) begin
      reading <= 1'b1;
      tx_byte <= status;
    end else if (reading && tx_ready) begin
      tx_byte <= status;
    end
  end

  a_r10_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && cs_active) |=> (!cs_active || (tx_valid && $stable(tx_byte))));
  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_byte[6:4] == 3'b000));
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import flash_sg_pkg::*;
#(
  parameter int unsigned T_WRSR     = 200,
  parameter int unsigned T_PP       = 3000,
  parameter int unsigned T_SE       = 20000,
  parameter int unsigned T_BE       = 60000,
  parameter int          SECTOR_BIT = 7
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       wp_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       busy
);
  logic       rst_all_n;
  cmd_t       cmd;
  logic       rd_start;
  logic       accept;
  logic       done;
  logic       start;
  logic       wel;
  logic       lock;
  logic [1:0] bp;
  logic [7:0] status;

  assign rst_all_n = rst_n && por_n;
  assign status    = {lock, 3'b000, bp, wel, busy};  // R1

  fsg_cmd_decode #(.SECTOR_BIT(SECTOR_BIT)) u_dec (
    .clk(clk), .rst_n(rst_all_n), .cs_active(cs_active),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .cmd(cmd), .rd_start(rd_start)
  );

  fsg_protect u_prot (
    .cmd(cmd), .busy(busy), .wel(wel), .lock(lock), .bp(bp),
    .wp_n(wp_n), .accept(accept)
  );

  assign start = accept && (cmd.kind inside {K_WRSR, K_PP, K_SE, K_BE});

  fsg_busy_timer #(.T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE)) u_tmr (
    .clk(clk), .rst_n(rst_all_n), .start(start), .kind(cmd.kind),
    .busy(busy), .done(done)
  );

  fsg_status_reader u_rd (
    .clk(clk), .rst_n(rst_all_n), .cs_active(cs_active), .rd_start(rd_start),
    .status(status), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  // R5 R11: volatile write-enable latch
  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n)                        wel <= 1'b0;
    else if (accept && cmd.kind == K_WREN) wel <= 1'b1;
    else if (accept && cmd.kind == K_WRDI) wel <= 1'b0;
    else if (done)                         wel <= 1'b0;
  end

  // R11: nonvolatile bits, cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock <= 1'b0;
      bp   <= 2'b00;
    end else if (accept && cmd.kind == K_WRSR) begin
      lock <= cmd.nv_lock;
      bp   <= cmd.nv_bp;
    end
  end

  a_r9_locked_bits_stable: assert property (@(posedge clk) disable iff (!rst_all_n)
    (lock && !wp_n) |=> $stable({lock, bp}));
  a_r4_cycle_needs_wel: assert property (@(posedge clk) disable iff (!rst_all_n)
    (busy && !$past(busy)) |-> wel);
  a_r3_busy_keeps_wel: assert property (@(posedge clk) disable iff (!rst_all_n)
    (busy && !done && cmd.valid) |=> ($stable(wel) && busy));
  a_r8_be_blocked: assert property (@(posedge clk) disable iff (!rst_all_n)
    (cmd.valid && cmd.kind == K_BE && bp != 2'b00 && !busy) |=> !busy);
endmodule

// File: tb/flash_status_guard_tb_top.sv
`timescale 1ns/1ps
module flash_status_guard_tb_top;
  localparam int unsigned TW = 10, TP = 5, TS = 9, TB = 14;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, cs_active = 1'b0, wp_n = 1'b1;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_byte = '0;
  logic tx_valid, busy;
  logic [7:0] tx_byte;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  flash_status_guard #(.T_WRSR(TW), .T_PP(TP), .T_SE(TS), .T_BE(TB)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_active(cs_active), .wp_n(wp_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .busy(busy)
  );

  typedef struct packed {
    logic [1:0] n;
    logic [7:0] b0, b1, b2;
    logic       wp;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h02, 4'd5},  // R5 set latch
    '{2'd1, 8'h04, 8'h00, 8'h00, 1'b1, 8'h00, 4'd5},  // R5 clear latch
    '{2'd2, 8'h01, 8'h8C, 8'h00, 1'b1, 8'h00, 4'd4},  // R4 no latch
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h02, 4'd5},
    '{2'd2, 8'h01, 8'h04, 8'h00, 1'b1, 8'h04, 4'd1},  // R1 protect=01
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h06, 4'd5},
    '{2'd1, 8'hC7, 8'h00, 8'h00, 1'b1, 8'h06, 4'd8},  // R8 blocked
    '{2'd2, 8'hD8, 8'h80, 8'h00, 1'b1, 8'h06, 4'd7},  // R7 upper guarded
    '{2'd2, 8'hD8, 8'h00, 8'h00, 1'b1, 8'h04, 4'd7},  // R7 lower free
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h06, 4'd5},
    '{2'd2, 8'h01, 8'h88, 8'h00, 1'b1, 8'h88, 4'd1},  // lock=1 protect=10
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h8A, 4'd5},
    '{2'd3, 8'h02, 8'h00, 8'h55, 1'b1, 8'h8A, 4'd7},  // R7 both guarded
    '{2'd2, 8'h01, 8'h00, 8'h00, 1'b0, 8'h8A, 4'd9},  // R9 hw lock
    '{2'd2, 8'h01, 8'h00, 8'h00, 1'b1, 8'h00, 4'd9},  // R9 pin high
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h02, 4'd5},
    '{2'd2, 8'hC7, 8'h00, 8'h00, 1'b1, 8'h02, 4'd6},  // R6 long BE
    '{2'd2, 8'h02, 8'h00, 8'h00, 1'b1, 8'h02, 4'd6},  // R6 short PP
    '{2'd1, 8'hC7, 8'h00, 8'h00, 1'b1, 8'h00, 4'd8},  // R8 runs
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b1, 8'h02, 4'd5},
    '{2'd2, 8'h01, 8'hF3, 8'h00, 1'b1, 8'h80, 4'd1},  // R1 masked bits
    '{2'd1, 8'h06, 8'h00, 8'h00, 1'b0, 8'h82, 4'd5},
    '{2'd2, 8'hD8, 8'h00, 8'h00, 1'b0, 8'h80, 4'd9}   // R9 SE not locked
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [7:0] b0, b1, b2);
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    @(negedge clk);
    cs_active = 1'b1;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_byte  = bs[i];
      @(negedge clk);
    end
    rx_valid  = 1'b0;
    cs_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] s);
    @(negedge clk);
    cs_active = 1'b1;
    rx_valid  = 1'b1;
    rx_byte   = 8'h05;
    @(negedge clk);
    rx_valid  = 1'b0;
    s = tx_valid ? tx_byte : 8'hEE;
    cs_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic count_busy(output int c);
    c = 0;
    while (busy) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic power_on();
    por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog act=0x0 exp=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, first, held;
    int c;
    power_on();
    // R11 reset state
    check(busy == 1'b0 && tx_valid == 1'b0, "R11", {tx_valid, busy}, 0);
    read_status(s);
    check(s == 8'h00, "R11", s, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wp_n = VECS[i].wp;
      xfer(VECS[i].n, VECS[i].b0, VECS[i].b1, VECS[i].b2);
      wait_idle();
      read_status(s);
      check(s == VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i), s, VECS[i].exp);
    end

    // R2 per-kind busy lengths and live WIP
    power_on();
    wp_n = 1'b1;
    xfer(1, 8'h06, 0, 0);
    xfer(2, 8'h01, 8'h00, 0);
    count_busy(c);
    check(c == TW, "R2 wrsr", c, TW);
    xfer(1, 8'h06, 0, 0);
    xfer(3, 8'h02, 8'h80, 8'hAA);
    count_busy(c);
    check(c == TP, "R2 pp", c, TP);
    xfer(1, 8'h06, 0, 0);
    xfer(2, 8'hD8, 8'h80, 0);
    count_busy(c);
    check(c == TS, "R2 se", c, TS);
    xfer(1, 8'h06, 0, 0);
    xfer(1, 8'hC7, 0, 0);
    count_busy(c);
    check(c == TB, "R2 be", c, TB);

    // R3 command during busy ignored, R10 read while busy
    xfer(1, 8'h06, 0, 0);
    xfer(2, 8'h01, 8'h00, 0);
    xfer(1, 8'h04, 0, 0);
    read_status(s);
    check(s == 8'h03, "R3", s, 8'h03);
    wait_idle();
    read_status(s);
    check(s == 8'h00, "R5 end clears", s, 8'h00);

    // R10 back-pressure hold, then fresh byte on handshake
    xfer(1, 8'h06, 0, 0);
    xfer(2, 8'h01, 8'h00, 0);
    @(negedge clk);
    cs_active = 1'b1; rx_valid = 1'b1; rx_byte = 8'h05;
    @(negedge clk);
    rx_valid = 1'b0;
    first = tx_byte;
    check(tx_valid && first == 8'h03, "R10 first", first, 8'h03);
    repeat (12) @(negedge clk);
    held = tx_byte;
    check(tx_valid && held == 8'h03, "R10 hold", held, 8'h03);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check(tx_valid && tx_byte == 8'h00, "R10 fresh", tx_byte, 8'h00);
    cs_active = 1'b0;
    @(negedge clk);
    check(tx_valid == 1'b0, "R10 drop", tx_valid, 0);

    // R11 logical reset keeps nonvolatile bits
    xfer(1, 8'h06, 0, 0);
    xfer(2, 8'h01, 8'h8C, 0);
    wait_idle();
    xfer(1, 8'h06, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    read_status(s);
    check(s == 8'h8C, "R11 rst", s, 8'h8C);
    power_on();
    read_status(s);
    check(s == 8'h00, "R11 por", s, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule